// File: doc/BRIEF.md
# IEEE 802.15.4 Receive Frame Filter

This block watches the bytes of a received IEEE 802.15.4 MAC frame as they stream in from the demodulator. The stream starts with the PHY length byte, followed by the frame control field (FCF), the sequence number and the addressing fields. From these it decides whether the frame is addressed to this node. The node's identity is a 16-bit PAN ID, a 16-bit short address and a 64-bit extended address. Per-type enables, an accept-any-address mode and a PAN-coordinator flag select which frames are wanted.

Address fields are not buffered. Each byte is compared with the matching byte of the local identity as it arrives, and any mismatch is held in a sticky flag. When the end strobe arrives, the block combines these flags with the frame-type rules. One cycle later it reports two things: an address-match pulse, which does not depend on FCS, and a verdict. The verdict accepts a frame only when the filter passes and the FCS-good input was high at the end strobe. A frame-valid pulse marks the moment the FCF has been fully received.

Top module: `mac_rx_filter`

## Requirements
- R1: With `cfg_any_addr` low, a frame is rejected when its frame type (FCF[2:0]) is 4..7, its version (FCF[13:12]) is 3, or either address mode (destination FCF[11:10], source FCF[15:14]) is 1.
- R2: When a destination PAN is present (destination mode 2 or 3), it must equal `cfg_pan_id` or 0xFFFF.
- R3: A short destination address (mode 2) must equal `cfg_short_addr` or 0xFFFF. An extended destination address (mode 3) must equal all 64 bits of `cfg_ext_addr`.
- R4: The field layout follows the standard order: length, FCF low byte then high byte, sequence number, destination PAN, destination address, source PAN, source address. Multi-byte fields arrive least significant byte first. When PAN ID compression (FCF[6]) is set and a destination is present, the source PAN field is absent and the destination PAN stands in for it.
- R5: A beacon (type 0) needs destination mode 0 and source mode 2 or 3. Its source PAN must equal `cfg_pan_id`, unless `cfg_pan_id` is 0xFFFF, in which case any source PAN is accepted.
- R6: Data (1), command (3) and reserved-type frames must carry a destination or a source address. If the destination is absent, `cfg_coordinator` must be high and the source PAN must equal `cfg_pan_id`.
- R7: An ACK (type 2) is accepted only if the length byte, with bit 7 cleared, equals 5.
- R8: `cfg_type_en` gates each type: bit 0 beacon, bit 1 data, bit 2 ACK, bit 3 command, bit 4 types 4..7. It applies in both modes.
- R9: With `cfg_any_addr` high, only R8 decides acceptance, and `addr_match` stays low.
- R10: `addr_match` is independent of `in_fcs_ok`. `verdict_accept` additionally requires `in_fcs_ok` high at the end strobe.
- R11: A frame that ends before its full addressing header has arrived is rejected in filtering mode.
- R12: After reset, all outputs are low. `frame_valid` pulses once, one cycle after the FCF high byte. `verdict_valid`, `verdict_accept` and `addr_match` appear one cycle after `in_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Received byte |
| in_sof | input | 1 | Marks the length byte (with in_valid) |
| in_eof | input | 1 | End of frame, in a cycle with no byte |
| in_fcs_ok | input | 1 | FCS result, sampled with in_eof |
| cfg_pan_id | input | 16 | Local PAN ID |
| cfg_short_addr | input | 16 | Local short address |
| cfg_ext_addr | input | 64 | Local extended address |
| cfg_type_en | input | 5 | Per-type accept enables |
| cfg_any_addr | input | 1 | Ignore addressing, keep type gating |
| cfg_coordinator | input | 1 | Node is PAN coordinator |
| frame_valid | output | 1 | FCF received pulse |
| addr_match | output | 1 | Filter passed (FCS-independent) |
| verdict_valid | output | 1 | Verdict strobe |
| verdict_accept | output | 1 | Frame accepted with good FCS |

## Verification
The bench covers the following cases and the failure each one would expose:
- Broadcast PAN and broadcast short address. A design that compared only against the local values would drop broadcast frames.
- A single wrong byte in the top of the extended address. A design that checked only part of the field would pass this frame.
- Beacons with a foreign source PAN, with and without a wildcard local PAN. Skipping the source PAN rule would let foreign beacons through.
- Frames with no destination, sent with and without coordinator status. Missing this rule would let a non-coordinator accept them.
- An ACK whose length byte has bit 7 set. A design that did not mask bit 7 would wrongly reject it.
- Reserved version and address-mode values, including a version of 1, which must still be accepted.
- Compressed-PAN layouts with trailing payload. Wrong field offsets here would make payload bytes corrupt the address flags.
- A bad FCS on a matching frame, which must still raise address match. A truncated header, which must be rejected.

// File: rtl/mac_filt_pkg.sv
package mac_filt_pkg;

    localparam int IDX_W       = 8;
    localparam int HDR_BASE    = 4;
    localparam int PAN_BYTES   = 2;
    localparam int SHORT_BYTES = 2;
    localparam int EXT_BYTES   = 8;
    localparam int PAN_W       = 8 * PAN_BYTES;
    localparam int SHORT_W     = 8 * SHORT_BYTES;
    localparam int EXT_W       = 8 * EXT_BYTES;
    localparam int NTYPE_EN    = 5;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] ACK_LEN = IDX_W'(5);

    typedef enum logic [1:0] {
        AM_NONE  = 2'd0,
        AM_RSVD  = 2'd1,
        AM_SHORT = 2'd2,
        AM_EXT   = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        FT_BEACON = 3'd0,
        FT_DATA   = 3'd1,
        FT_ACK    = 3'd2,
        FT_CMD    = 3'd3
    } ftype_e;

    // FCF, bit 15 first
    typedef struct packed {
        amode_e     src_mode;
        logic [1:0] version;
        amode_e     dst_mode;
        logic [2:0] mid;
        logic       pan_comp;
        logic       ack_req;
        logic       pending;
        logic       security;
        logic [2:0] ftype;
    } fcf_t;

    typedef struct packed {
        logic [IDX_W-1:0] dpan_o;
        logic [IDX_W-1:0] dadr_o;
        logic [IDX_W-1:0] span_o;
        logic [IDX_W-1:0] hdr_end;
        logic             has_span;
    } layout_t;

    // sticky "differs" flags gathered while streaming
    typedef struct packed {
        logic dpan_loc;
        logic dpan_bc;
        logic dsh_loc;
        logic dsh_bc;
        logic dext;
        logic span_loc;
    } mism_t;

    function automatic logic addr_present(input amode_e m);
        return (m == AM_SHORT) || (m == AM_EXT);
    endfunction

    function automatic logic [IDX_W-1:0] amode_bytes(input amode_e m);
        case (m)
            AM_SHORT: return IDX_W'(SHORT_BYTES);
            AM_EXT:   return IDX_W'(EXT_BYTES);
            default:  return '0;
        endcase
    endfunction

    function automatic layout_t calc_layout(input fcf_t f);
        layout_t    l;
        logic       dpres;
        logic       spres;
        logic [IDX_W-1:0] sadr;
        dpres      = addr_present(f.dst_mode);
        spres      = addr_present(f.src_mode);
        l.has_span = spres && !(f.pan_comp && dpres);
        l.dpan_o   = IDX_W'(HDR_BASE);
        l.dadr_o   = l.dpan_o + (dpres ? IDX_W'(PAN_BYTES) : '0);
        l.span_o   = l.dadr_o + amode_bytes(f.dst_mode);
        sadr       = l.span_o + (l.has_span ? IDX_W'(PAN_BYTES) : '0);
        l.hdr_end  = sadr + amode_bytes(f.src_mode);
        return l;
    endfunction

    function automatic logic type_enabled(input logic [2:0] ft,
                                          input logic [NTYPE_EN-1:0] en);
        case (ft)
            FT_BEACON: return en[0];
            FT_DATA:   return en[1];
            FT_ACK:    return en[2];
            FT_CMD:    return en[3];
            default:   return en[4];
        endcase
    endfunction

endpackage

// File: rtl/mac_hdr_track.sv
module mac_hdr_track
    import mac_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_sof,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] cnt_q,
    output logic [IDX_W-1:0] len7_q,
    output fcf_t             fcf_q,
    output layout_t          lay,
    output logic             frame_valid
);
    logic [7:0] fcf_lo_q;

    assign idx = in_sof ? '0 : cnt_q;
    assign lay = calc_layout(fcf_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            len7_q      <= '0;
            fcf_lo_q    <= '0;
            fcf_q       <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= in_valid && (idx == IDX_W'(2));
            if (in_valid) begin
                if (in_sof)
                    cnt_q <= IDX_W'(1);
                else if (cnt_q != IDX_MAX)
                    cnt_q <= cnt_q + IDX_W'(1);
                if (idx == '0)
                    len7_q <= IDX_W'(in_byte[6:0]);
                if (idx == IDX_W'(1))
                    fcf_lo_q <= in_byte;
                if (idx == IDX_W'(2))
                    fcf_q <= fcf_t'({in_byte, fcf_lo_q});
            end
        end
    end

    // R12
    fv_after_fcf_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (cnt_q == IDX_W'(3)));

endmodule

// File: rtl/mac_field_cmp.sv
module mac_field_cmp
    import mac_filt_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             field_on,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] base,
    input  logic [7:0]       in_byte,
    input  logic [8*NB-1:0]  ref_val,
    output logic             ne_ref,
    output logic             ne_ones
);
    logic [NB-1:0] mis_ref;
    logic [NB-1:0] mis_one;

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic hit;
        assign hit        = field_on && in_valid && !clr && (idx == base + IDX_W'(j));
        assign mis_ref[j] = hit && (in_byte != ref_val[8*j +: 8]);
        assign mis_one[j] = hit && (in_byte != 8'hFF);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ne_ref  <= 1'b0;
            ne_ones <= 1'b0;
        end else begin
            ne_ref  <= ne_ref  | (|mis_ref);
            ne_ones <= ne_ones | (|mis_one);
        end
    end

    // R4
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!ne_ref && !ne_ones));

endmodule

// File: rtl/mac_filt_rules.sv
module mac_filt_rules
    import mac_filt_pkg::*;
(
    input  fcf_t                fcf,
    input  logic [IDX_W-1:0]    hdr_end,
    input  logic                has_span,
    input  logic [IDX_W-1:0]    cnt,
    input  logic [IDX_W-1:0]    len7,
    input  mism_t               mm,
    input  logic [PAN_W-1:0]    cfg_pan_id,
    input  logic [NTYPE_EN-1:0] cfg_type_en,
    input  logic                cfg_coordinator,
    output logic                type_ok,
    output logic                filt_pass
);
    logic rsvd, dpres, spres, complete, dst_ok, span_eq, rule_ok;
    logic unused_fcf;

    assign unused_fcf = ^{fcf.mid, fcf.ack_req, fcf.pending, fcf.security};

    always_comb begin
        type_ok  = type_enabled(fcf.ftype, cfg_type_en);
        rsvd     = fcf.ftype[2] || (fcf.version == 2'd3) ||
                   (fcf.dst_mode == AM_RSVD) || (fcf.src_mode == AM_RSVD);
        dpres    = addr_present(fcf.dst_mode);
        spres    = addr_present(fcf.src_mode);
        complete = (cnt >= hdr_end);

        dst_ok = 1'b1;
        if (dpres) begin
            dst_ok = !mm.dpan_loc || !mm.dpan_bc;
            if (fcf.dst_mode == AM_SHORT)
                dst_ok = dst_ok && (!mm.dsh_loc || !mm.dsh_bc);
            else
                dst_ok = dst_ok && !mm.dext;
        end

        if (has_span)
            span_eq = !mm.span_loc;
        else if (fcf.pan_comp && dpres)
            span_eq = !mm.dpan_loc;
        else
            span_eq = 1'b0;

        case (fcf.ftype)
            FT_BEACON: rule_ok = !dpres && spres &&
                                 ((cfg_pan_id == '1) || span_eq);
            FT_ACK:    rule_ok = (len7 == ACK_LEN);
            default:   rule_ok = (dpres || spres) &&
                                 (dpres || (cfg_coordinator && span_eq));
        endcase

        filt_pass = type_ok && !rsvd && complete && dst_ok && rule_ok;
    end

endmodule

// File: rtl/mac_rx_filter.sv
module mac_rx_filter
    import mac_filt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_byte,
    input  logic                in_sof,
    input  logic                in_eof,
    input  logic                in_fcs_ok,
    input  logic [PAN_W-1:0]    cfg_pan_id,
    input  logic [SHORT_W-1:0]  cfg_short_addr,
    input  logic [EXT_W-1:0]    cfg_ext_addr,
    input  logic [NTYPE_EN-1:0] cfg_type_en,
    input  logic                cfg_any_addr,
    input  logic                cfg_coordinator,
    output logic                frame_valid,
    output logic                addr_match,
    output logic                verdict_valid,
    output logic                verdict_accept
);
    logic [IDX_W-1:0] idx, cnt, len7;
    fcf_t             fcf;
    layout_t          lay;
    mism_t            mm;
    logic             clr, type_ok, filt_pass;
    logic             dext_ones, span_ones;
    logic             unused_ones;

    assign clr         = in_valid && in_sof;
    assign unused_ones = dext_ones ^ span_ones;

    mac_hdr_track u_track (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_sof(in_sof), .idx(idx), .cnt_q(cnt), .len7_q(len7),
        .fcf_q(fcf), .lay(lay), .frame_valid(frame_valid)
    );

    mac_field_cmp #(.NB(PAN_BYTES)) u_dpan (
        .clk(clk), .rst(rst), .clr(clr),
        .field_on(addr_present(fcf.dst_mode)), .in_valid(in_valid),
        .idx(idx), .base(lay.dpan_o), .in_byte(in_byte), .ref_val(cfg_pan_id),
        .ne_ref(mm.dpan_loc), .ne_ones(mm.dpan_bc)
    );

    mac_field_cmp #(.NB(SHORT_BYTES)) u_dshort (
        .clk(clk), .rst(rst), .clr(clr),
        .field_on(fcf.dst_mode == AM_SHORT), .in_valid(in_valid),
        .idx(idx), .base(lay.dadr_o), .in_byte(in_byte), .ref_val(cfg_short_addr),
        .ne_ref(mm.dsh_loc), .ne_ones(mm.dsh_bc)
    );

    mac_field_cmp #(.NB(EXT_BYTES)) u_dext (
        .clk(clk), .rst(rst), .clr(clr),
        .field_on(fcf.dst_mode == AM_EXT), .in_valid(in_valid),
        .idx(idx), .base(lay.dadr_o), .in_byte(in_byte), .ref_val(cfg_ext_addr),
        .ne_ref(mm.dext), .ne_ones(dext_ones)
    );

    mac_field_cmp #(.NB(PAN_BYTES)) u_span (
        .clk(clk), .rst(rst), .clr(clr),
        .field_on(lay.has_span), .in_valid(in_valid),
        .idx(idx), .base(lay.span_o), .in_byte(in_byte), .ref_val(cfg_pan_id),
        .ne_ref(mm.span_loc), .ne_ones(span_ones)
    );

    mac_filt_rules u_rules (
        .fcf(fcf), .hdr_end(lay.hdr_end), .has_span(lay.has_span),
        .cnt(cnt), .len7(len7), .mm(mm), .cfg_pan_id(cfg_pan_id),
        .cfg_type_en(cfg_type_en), .cfg_coordinator(cfg_coordinator),
        .type_ok(type_ok), .filt_pass(filt_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_match     <= 1'b0;
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid  <= in_eof;
            addr_match     <= in_eof && !cfg_any_addr && filt_pass;
            verdict_accept <= in_eof && in_fcs_ok &&
                              (cfg_any_addr ? type_ok : filt_pass);
        end
    end

    // R12
    match_in_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        addr_match |-> verdict_valid);

    // R12
    accept_in_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        verdict_accept |-> verdict_valid);

    // R10
    accept_needs_fcs_chk: assert property (@(posedge clk) disable iff (rst)
        verdict_accept |-> $past(in_fcs_ok));

    // R9
    no_match_any_addr_chk: assert property (@(posedge clk) disable iff (rst)
        addr_match |-> $past(!cfg_any_addr));

endmodule

// File: tb/tb_mac_rx_filter.sv
module tb_mac_rx_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_fcs_ok = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [15:0] cfg_pan_id = 16'h1234;
    logic [15:0] cfg_short_addr = 16'hBEEF;
    logic [63:0] cfg_ext_addr = 64'h0123_4567_89AB_CDEF;
    logic [4:0]  cfg_type_en = 5'h1F;
    logic        cfg_any_addr = 1'b0, cfg_coordinator = 1'b0;
    logic        frame_valid, addr_match, verdict_valid, verdict_accept;

    always #10 clk = ~clk;

    mac_rx_filter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_sof(in_sof), .in_eof(in_eof), .in_fcs_ok(in_fcs_ok),
        .cfg_pan_id(cfg_pan_id), .cfg_short_addr(cfg_short_addr),
        .cfg_ext_addr(cfg_ext_addr), .cfg_type_en(cfg_type_en),
        .cfg_any_addr(cfg_any_addr), .cfg_coordinator(cfg_coordinator),
        .frame_valid(frame_valid), .addr_match(addr_match),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    typedef struct { bit acc; bit am; string tag; } exp_t;
    exp_t       sb[$];
    logic [7:0] fb[$];
    int         n_chk = 0, n_bad = 0, fv_seen = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on each verdict
    always @(negedge clk) begin
        exp_t e;
        if (frame_valid) fv_seen++;
        if (verdict_valid) begin
            if (sb.size() == 0)
                chk(0, "R12", "verdict without frame", 1, 0);
            else begin
                e = sb.pop_front();
                chk(verdict_accept == e.acc, e.tag, "verdict_accept",
                    int'(verdict_accept), int'(e.acc));
                chk(addr_match == e.am, e.tag, "addr_match",
                    int'(addr_match), int'(e.am));
            end
        end
    end

    task automatic hdr(input [2:0] ft, input bit pc, input [1:0] dm,
                       input [1:0] ver, input [1:0] sm);
        logic [15:0] f;
        f = {sm, ver, dm, 3'b000, pc, 1'b1, 1'b0, 1'b0, ft};
        fb.delete();
        fb.push_back(8'h00);
        fb.push_back(f[7:0]);
        fb.push_back(f[15:8]);
        fb.push_back(8'h5A);
    endtask

    task automatic p16(input [15:0] v);
        fb.push_back(v[7:0]);
        fb.push_back(v[15:8]);
    endtask

    task automatic p64(input [63:0] v);
        for (int i = 0; i < 8; i++) fb.push_back(v[8*i +: 8]);
    endtask

    task automatic fin();
        fb.push_back(8'hA7);
        fb.push_back(8'h3C);
        fb[0] = 8'(fb.size() - 1);
    endtask

    // driver: pushes the expectation, streams the frame, ends it
    task automatic send(input bit fcs, input bit acc, input bit am, input string tag);
        exp_t e;
        int   fv_exp;
        e.acc = acc; e.am = am; e.tag = tag;
        sb.push_back(e);
        fv_seen = 0;
        fv_exp  = (fb.size() >= 3) ? 1 : 0;
        for (int i = 0; i < fb.size(); i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_byte = fb[i]; in_sof = (i == 0);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b1; in_fcs_ok = fcs;
        @(posedge clk); #1;
        in_eof = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(fv_seen == fv_exp, "R12", "frame_valid pulses", fv_seen, fv_exp);
        chk(sb.size() == 0, "R12", "missing verdict", sb.size(), 0);
        sb.delete();
    endtask

    task automatic good_short();
        hdr(3'd1, 1'b1, 2'd2, 2'd0, 2'd2);
        p16(16'h1234); p16(16'hBEEF); p16(16'h0001);
        fb.push_back(8'h11); fb.push_back(8'h22);
        fin();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R12", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk({frame_valid, addr_match, verdict_valid, verdict_accept} == 4'b0,
            "R12", "outputs after reset",
            int'({frame_valid, addr_match, verdict_valid, verdict_accept}), 0);

        // R4 compressed PAN, payload after header
        good_short();                          send(1, 1, 1, "R4");
        // R2 R3 broadcast PAN and short address
        hdr(3'd1, 1'b1, 2'd2, 2'd0, 2'd2);
        p16(16'hFFFF); p16(16'hFFFF); p16(16'h0001); fin(); send(1, 1, 1, "R2");
        // R2 wrong PAN
        hdr(3'd1, 1'b1, 2'd2, 2'd0, 2'd2);
        p16(16'h1235); p16(16'hBEEF); p16(16'h0001); fin(); send(1, 0, 0, "R2");
        // R3 wrong short address
        hdr(3'd1, 1'b1, 2'd2, 2'd0, 2'd2);
        p16(16'h1234); p16(16'hBEEE); p16(16'h0001); fin(); send(1, 0, 0, "R3");
        // R3 extended match, then mismatch in top byte
        hdr(3'd1, 1'b0, 2'd3, 2'd0, 2'd0);
        p16(16'h1234); p64(64'h0123_4567_89AB_CDEF); fin(); send(1, 1, 1, "R3");
        hdr(3'd1, 1'b0, 2'd3, 2'd0, 2'd0);
        p16(16'h1234); p64(64'h0023_4567_89AB_CDEF); fin(); send(1, 0, 0, "R3");

        // R5 beacon rules
        hdr(3'd0, 1'b0, 2'd0, 2'd0, 2'd2);
        p16(16'h1234); p16(16'h0042); fin();    send(1, 1, 1, "R5");
        hdr(3'd0, 1'b0, 2'd0, 2'd0, 2'd2);
        p16(16'h7777); p16(16'h0042); fin();    send(1, 0, 0, "R5");
        hdr(3'd0, 1'b1, 2'd2, 2'd0, 2'd2);
        p16(16'h1234); p16(16'hBEEF); p16(16'h0042); fin(); send(1, 0, 0, "R5");
        cfg_pan_id = 16'hFFFF;
        hdr(3'd0, 1'b0, 2'd0, 2'd0, 2'd3);
        p16(16'h7777); p64(64'h1); fin();       send(1, 1, 1, "R5");
        cfg_pan_id = 16'h1234;

        // R6 no destination
        hdr(3'd1, 1'b0, 2'd0, 2'd0, 2'd2);
        p16(16'h1234); p16(16'h0042); fin();    send(1, 0, 0, "R6");
        cfg_coordinator = 1'b1;
        hdr(3'd3, 1'b0, 2'd0, 2'd0, 2'd2);
        p16(16'h1234); p16(16'h0042); fin();    send(1, 1, 1, "R6");
        hdr(3'd1, 1'b0, 2'd0, 2'd0, 2'd2);
        p16(16'h1235); p16(16'h0042); fin();    send(1, 0, 0, "R6");
        hdr(3'd1, 1'b0, 2'd0, 2'd0, 2'd0);
        fin();                                  send(1, 0, 0, "R6");
        cfg_coordinator = 1'b0;

        // R7 ACK length
        hdr(3'd2, 1'b0, 2'd0, 2'd0, 2'd0); fin(); send(1, 1, 1, "R7");
        hdr(3'd2, 1'b0, 2'd0, 2'd0, 2'd0); fin(); fb[0] = 8'h85; send(1, 1, 1, "R7");
        hdr(3'd2, 1'b0, 2'd0, 2'd0, 2'd0); fb.push_back(8'h00); fin();
        send(1, 0, 0, "R7");

        // R1 reserved subfields
        hdr(3'd1, 1'b1, 2'd2, 2'd3, 2'd2);
        p16(16'h1234); p16(16'hBEEF); p16(16'h0001); fin(); send(1, 0, 0, "R1");
        hdr(3'd1, 1'b1, 2'd2, 2'd1, 2'd2);
        p16(16'h1234); p16(16'hBEEF); p16(16'h0001); fin(); send(1, 1, 1, "R1");
        hdr(3'd1, 1'b0, 2'd1, 2'd0, 2'd2);
        p16(16'h1234); p16(16'h0001); fin();    send(1, 0, 0, "R1");
        hdr(3'd5, 1'b1, 2'd2, 2'd0, 2'd2);
        p16(16'h1234); p16(16'hBEEF); p16(16'h0001); fin(); send(1, 0, 0, "R1");

        // R8 type enable off
        cfg_type_en = 5'b11101;
        good_short();                           send(1, 0, 0, "R8");
        cfg_type_en = 5'h1F;

        // R10 bad FCS keeps address match
        good_short();                           send(0, 0, 1, "R10");

        // R11 truncated header
        hdr(3'd1, 1'b0, 2'd2, 2'd0, 2'd0);
        p16(16'h1234); fb.push_back(8'hEF); fb[0] = 8'(fb.size() - 1);
        send(1, 0, 0, "R11");

        // R9 accept-any-address mode
        cfg_any_addr = 1'b1;
        hdr(3'd1, 1'b1, 2'd2, 2'd0, 2'd2);
        p16(16'h9999); p16(16'h1111); p16(16'h0001); fin(); send(1, 1, 0, "R9");
        hdr(3'd5, 1'b0, 2'd1, 2'd3, 2'd1); fin(); send(1, 1, 0, "R9");
        cfg_type_en = 5'b11101;
        hdr(3'd1, 1'b1, 2'd2, 2'd0, 2'd2);
        p16(16'h9999); p16(16'h1111); p16(16'h0001); fin(); send(1, 0, 0, "R8");
        cfg_type_en = 5'h1F;
        cfg_any_addr = 1'b0;

        good_short();                           send(1, 1, 1, "R4");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule